// File: doc/BRIEF.md
# Machine-Cycle Sequencer with Request Arbitration

This block steps a small 8-bit processor through its machine cycles. Each machine cycle lasts a fixed number of clock periods. In every cycle the block drives a 2-bit state code that names the cycle type: fetch, execute, DMA transfer or interrupt acknowledge. It also drives two timing pulses, the address strobe and the data strobe, which I/O controllers use to time their accesses. The instruction decoder, the ALU, the memory and the I/O devices sit outside the block. They reach it only through an "instruction complete" input, an "idle instruction" input and a small designator write port.

At the end of each execute cycle that finishes an instruction, the block resolves the pending requests. A DMA-in request beats a DMA-out request, and a DMA-out request beats an enabled interrupt. A DMA cycle takes its address from the R0 pointer and advances the pointer afterwards. An interrupt cycle saves the X and P designators into the save register, then forces X to 2 and P to 1 and disables further interrupts. The four external status flags are captured at the start of every execute cycle, and branch logic uses the captured copy.

Top module: `cycle_sequencer`

## Requirements
- R1: `state_code` is 00 in a fetch cycle, 01 in an execute cycle, 10 in a DMA cycle and 11 in an interrupt cycle. It holds one value for the whole machine cycle of 8 clock periods, which are numbered 0 to 7.
- R2: `tpa` is high in period 1 only and `tpb` is high in period 6 only, so each pulses exactly once per machine cycle.
- R3: A fetch cycle is always followed by an execute cycle. Requests present during a fetch cycle are not acted on.
- R4: Requests are sampled in the last period (7) of an execute cycle and are acted on only if `instr_done` or `is_idle` is high there. If `instr_done` is high, `is_idle` is low and no request is taken, the next cycle is a fetch. If neither `instr_done` nor `is_idle` is high, the next cycle is another execute cycle.
- R5: When requests arrive together, DMA-in wins over DMA-out, and DMA-out wins over interrupt. During a DMA cycle `dma_to_mem` is 1 for a DMA-in transfer and 0 for a DMA-out transfer.
- R6: `r0_ptr` is the DMA address and increments by one at the end of every DMA cycle. A DMA cycle is followed by another DMA cycle while either DMA request is high in its period 7, and by a fetch otherwise.
- R7: An interrupt is taken only while `int_en` is 1. The interrupt cycle lasts one machine cycle. At its end `t_save` = {X, P} with X in the upper nibble, X becomes 2, P becomes 1 and `int_en` becomes 0. The next cycle is a fetch.
- R8: `flags_q` loads `ext_flags` on the clock edge that begins every execute cycle, and holds that value at all other times.
- R9: An idle instruction (`is_idle` high during execute) with no request repeats the execute cycle. While `load_mode` is also high, `tpa` is suppressed in those cycles and `tpb` still pulses.
- R10: If `des_wr` is high in period 7 of an execute cycle, X, P and `int_en` take `des_x`, `des_p` and `des_ie` at the end of that cycle.
- R11: Reset gives a fetch cycle in period 0, X = P = 0, `t_save` = 0, `r0_ptr` = 0, `flags_q` = 0 and `int_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_done | input | 1 | Current execute cycle completes the instruction |
| is_idle | input | 1 | Current instruction is the idle instruction |
| load_mode | input | 1 | Load mode; suppresses tpa while idling |
| dma_in_req | input | 1 | DMA request, device to memory |
| dma_out_req | input | 1 | DMA request, memory to device |
| irq_req | input | 1 | Interrupt request |
| ext_flags | input | 4 | External status flags |
| des_wr | input | 1 | Designator write strobe, taken at end of execute |
| des_x | input | 4 | New X designator |
| des_p | input | 4 | New P designator |
| des_ie | input | 1 | New interrupt enable |
| state_code | output | 2 | Machine-cycle type |
| tpa | output | 1 | First timing pulse (address strobe) |
| tpb | output | 1 | Second timing pulse (data strobe) |
| dma_to_mem | output | 1 | DMA direction, 1 = device to memory |
| flags_q | output | 4 | Flags captured at start of execute |
| x_des | output | 4 | X designator |
| p_des | output | 4 | P designator |
| t_save | output | 8 | Saved {X, P} from the last interrupt |
| int_en | output | 1 | Interrupt enable |
| r0_ptr | output | 16 | DMA address pointer R0 |

## Verification
The assertions take for granted that every request, `instr_done`, `is_idle` and the designator write inputs are stable across period 7 of a machine cycle. They also assume that no clock edge other than the end of period 7 moves the cycle type. The bench changes all inputs only at a falling clock edge while the phase is 0, and holds them for a whole machine cycle. As a result, each decision the block makes sees exactly one set of inputs.

// File: rtl/cycle_sequencer.sv
module cycle_sequencer #(
  parameter int CYC_LEN = 8,
  parameter int TPA_AT  = 1,
  parameter int TPB_AT  = 6,
  parameter int DES_W   = 4,
  parameter int FLAG_W  = 4,
  parameter int ADDR_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_done,
  input  logic                 is_idle,
  input  logic                 load_mode,
  input  logic                 dma_in_req,
  input  logic                 dma_out_req,
  input  logic                 irq_req,
  input  logic [FLAG_W-1:0]    ext_flags,
  input  logic                 des_wr,
  input  logic [DES_W-1:0]     des_x,
  input  logic [DES_W-1:0]     des_p,
  input  logic                 des_ie,
  output logic [1:0]           state_code,
  output logic                 tpa,
  output logic                 tpb,
  output logic                 dma_to_mem,
  output logic [FLAG_W-1:0]    flags_q,
  output logic [DES_W-1:0]     x_des,
  output logic [DES_W-1:0]     p_des,
  output logic [2*DES_W-1:0]   t_save,
  output logic                 int_en,
  output logic [ADDR_W-1:0]    r0_ptr
);
  localparam int PH_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_LEN - 1);
  localparam logic [PH_W-1:0] PH_TPA  = PH_W'(TPA_AT);
  localparam logic [PH_W-1:0] PH_TPB  = PH_W'(TPB_AT);

  typedef enum logic [1:0] {
    ST_FETCH = 2'b00,
    ST_EXEC  = 2'b01,
    ST_DMA   = 2'b10,
    ST_INTR  = 2'b11
  } state_t;

  state_t           state_q, state_d;
  logic [PH_W-1:0]  phase_q;
  logic             dir_q, dir_d;

  wire cyc_end  = (phase_q == PH_LAST);
  wire dma_any  = dma_in_req | dma_out_req;
  wire irq_ok   = irq_req & int_en;
  wire boundary = instr_done | is_idle;
  wire idle_ld  = (state_q == ST_EXEC) & is_idle & load_mode;

  assign state_code = state_q;
  assign tpa        = (phase_q == PH_TPA) & ~idle_ld;
  assign tpb        = (phase_q == PH_TPB);
  assign dma_to_mem = dir_q;

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    unique case (state_q)
      ST_FETCH: state_d = ST_EXEC;
      ST_EXEC: begin
        if (boundary && dma_any) begin
          state_d = ST_DMA;
          dir_d   = dma_in_req;
        end else if (boundary && irq_ok) begin
          state_d = ST_INTR;
        end else if (instr_done && !is_idle) begin
          state_d = ST_FETCH;
        end else begin
          state_d = ST_EXEC;
        end
      end
      ST_DMA: begin
        if (dma_any) begin
          state_d = ST_DMA;
          dir_d   = dma_in_req;
        end else begin
          state_d = ST_FETCH;
        end
      end
      ST_INTR: state_d = ST_FETCH;
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      state_q <= ST_FETCH;
      dir_q   <= 1'b0;
    end else begin
      phase_q <= cyc_end ? '0 : phase_q + PH_W'(1);
      if (cyc_end) begin
        state_q <= state_d;
        dir_q   <= dir_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else if (cyc_end && state_d == ST_EXEC) flags_q <= ext_flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r0_ptr <= '0;
    else if (cyc_end && state_q == ST_DMA) r0_ptr <= r0_ptr + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_des  <= '0;
      p_des  <= '0;
      t_save <= '0;
      int_en <= 1'b1;
    end else if (cyc_end && state_q == ST_INTR) begin
      t_save <= {x_des, p_des};
      x_des  <= DES_W'(2);
      p_des  <= DES_W'(1);
      int_en <= 1'b0;
    end else if (cyc_end && state_q == ST_EXEC && des_wr) begin
      x_des  <= des_x;
      p_des  <= des_p;
      int_en <= des_ie;
    end
  end

  // R1
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state_code) |-> $past(phase_q) == PH_LAST);
  // R2
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tpa && tpb));
  // R3
  fetch_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 2'b00 && cyc_end) |=> state_code == 2'b01);
  // R5
  dmain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 2'b01 && cyc_end && boundary && dma_in_req) |=> (state_code == 2'b10 && dma_to_mem));
  // R6
  r0_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 2'b10 && cyc_end) |=> r0_ptr == $past(r0_ptr) + ADDR_W'(1));
  // R7
  intr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 2'b11 && cyc_end) |=> (state_code == 2'b00 && x_des == DES_W'(2) && p_des == DES_W'(1) && !int_en));
  // R7
  intr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_code == 2'b11) |-> $past(int_en));
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flags_q) |-> state_code == 2'b01 && phase_q == '0);
  // R9
  idle_tpa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 2'b01 && is_idle && load_mode) |-> !tpa);
endmodule

// File: tb/cycle_sequencer_tb.sv
`timescale 1ns/1ps
module cycle_sequencer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_done = 1'b1, is_idle = 1'b0, load_mode = 1'b0;
  logic dma_in_req = 1'b0, dma_out_req = 1'b0, irq_req = 1'b0;
  logic [3:0] ext_flags = 4'h0;
  logic des_wr = 1'b0, des_ie = 1'b1;
  logic [3:0] des_x = 4'h0, des_p = 4'h0;
  logic [1:0] state_code;
  logic tpa, tpb, dma_to_mem, int_en;
  logic [3:0] flags_q, x_des, p_des;
  logic [7:0] t_save;
  logic [15:0] r0_ptr;

  int checks = 0, fails = 0;
  int m_state = 0, m_x = 0, m_p = 0, m_t = 0, m_ie = 1, m_r0 = 0, m_fl = 0, m_dir = 0;

  always #4 clk = ~clk;

  cycle_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .is_idle(is_idle),
    .load_mode(load_mode), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req),
    .irq_req(irq_req), .ext_flags(ext_flags), .des_wr(des_wr), .des_x(des_x),
    .des_p(des_p), .des_ie(des_ie), .state_code(state_code), .tpa(tpa), .tpb(tpb),
    .dma_to_mem(dma_to_mem), .flags_q(flags_q), .x_des(x_des), .p_des(p_des),
    .t_save(t_save), .int_en(int_en), .r0_ptr(r0_ptr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk(x_des == 4'(m_x) && p_des == 4'(m_p) && int_en == 1'(m_ie),
        {req, " designators"}, {x_des, p_des, 3'b0, int_en}, (m_x << 12) | (m_p << 8) | m_ie);
    chk(t_save == 8'(m_t), {req, " t_save"}, t_save, m_t);
    chk(r0_ptr == 16'(m_r0), {req, " r0_ptr"}, r0_ptr, m_r0);
    chk(flags_q == 4'(m_fl), {req, " flags_q"}, flags_q, m_fl);
  endtask

  // One machine cycle: inputs held, outputs checked in every period, model stepped.
  task automatic mc(input string req);
    bit sc_bad = 0, pulse_bad = 0, dir_bad = 0;
    int nxt;
    bit fin;
    for (int i = 0; i < 8; i++) begin
      bit e_tpa = (i == 1) && !(m_state == 1 && is_idle && load_mode);
      if (state_code !== 2'(m_state)) sc_bad = 1;
      if (tpa !== e_tpa || tpb !== (i == 6)) pulse_bad = 1;
      if (m_state == 2 && dma_to_mem !== 1'(m_dir)) dir_bad = 1;
      @(posedge clk);
      @(negedge clk);
    end
    chk(!sc_bad, {req, " R1 state code"}, state_code, m_state);
    chk(!pulse_bad, {req, " R2 pulses"}, {tpa, tpb}, 0);
    if (m_state == 2) chk(!dir_bad, {req, " R5 dma_to_mem"}, dma_to_mem, m_dir);
    fin = instr_done | is_idle;
    nxt = m_state;
    case (m_state)
      0: nxt = 1;
      1: begin
        if (fin && (dma_in_req || dma_out_req)) begin nxt = 2; m_dir = dma_in_req; end
        else if (fin && irq_req && m_ie == 1) nxt = 3;
        else if (instr_done && !is_idle) nxt = 0;
        else nxt = 1;
        if (des_wr) begin m_x = des_x; m_p = des_p; m_ie = des_ie; end
      end
      2: begin
        m_r0 = (m_r0 + 1) & 16'hffff;
        if (dma_in_req || dma_out_req) begin nxt = 2; m_dir = dma_in_req; end
        else nxt = 0;
      end
      default: begin
        m_t = (m_x << 4) | m_p; m_x = 2; m_p = 1; m_ie = 0; nxt = 0;
      end
    endcase
    if (nxt == 1) m_fl = ext_flags;
    m_state = nxt;
    chk_regs(req);
  endtask

  task automatic quiet();
    dma_in_req = 0; dma_out_req = 0; irq_req = 0; des_wr = 0;
    instr_done = 1; is_idle = 0; load_mode = 0;
  endtask

  task automatic drain(input string req);
    quiet();
    for (int k = 0; k < 6 && m_state != 0; k++) mc(req);
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(state_code == 2'b00 && !tpa && !tpb, "R11 reset outputs", {state_code, tpa, tpb}, 0);
    chk_regs("R11 reset");
    rst_n = 1'b1;

    // R3 R8: fetch/execute alternation and flag capture
    ext_flags = 4'hA;
    mc("R3 fetch");
    chk(flags_q == 4'hA, "R8 capture at execute start", flags_q, 4'hA);
    ext_flags = 4'h5;
    mc("R4 execute done");
    chk(flags_q == 4'hA, "R8 hold outside execute start", flags_q, 4'hA);
    // R3 requests during fetch ignored
    dma_in_req = 1; irq_req = 1;
    mc("R3 fetch with requests");
    chk(state_code == 2'b01, "R3 fetch -> execute despite requests", state_code, 1);
    quiet();
    // R4 multi-cycle execute
    instr_done = 0;
    mc("R4 execute not done");
    chk(state_code == 2'b01, "R4 repeat execute", state_code, 1);
    chk(flags_q == 4'h5, "R8 capture on repeated execute", flags_q, 5);
    instr_done = 1;
    mc("R4 execute done");

    // R10 designator write then R7 interrupt saves it
    mc("R3 fetch");
    des_wr = 1; des_x = 4'h5; des_p = 4'h3; des_ie = 1;
    mc("R10 designator write");
    chk(x_des == 4'h5 && p_des == 4'h3, "R10 write applied", {x_des, p_des}, 8'h53);
    quiet();
    mc("R3 fetch");
    irq_req = 1;
    mc("R7 execute with irq");
    chk(state_code == 2'b11, "R7 interrupt taken", state_code, 3);
    mc("R7 interrupt cycle");
    chk(t_save == 8'h53 && x_des == 4'h2 && p_des == 4'h1 && !int_en,
        "R7 interrupt entry", {t_save, x_des, p_des, 3'b0, int_en}, 32'h5321_0);
    chk(state_code == 2'b00, "R7 fetch after interrupt", state_code, 0);
    mc("R3 fetch");
    mc("R7 irq masked");
    chk(state_code == 2'b00, "R7 masked irq ignored", state_code, 0);
    quiet();

    // R5 R6 DMA chain
    mc("R3 fetch");
    dma_in_req = 1; dma_out_req = 1; irq_req = 1;
    mc("R5 all requests");
    chk(state_code == 2'b10 && dma_to_mem, "R5 dma-in wins", {state_code, dma_to_mem}, 3'b101);
    mc("R6 dma chain 1");
    dma_in_req = 0;
    mc("R6 dma chain 2");
    chk(state_code == 2'b10 && !dma_to_mem, "R5 dma-out next", {state_code, dma_to_mem}, 3'b100);
    dma_out_req = 0;
    mc("R6 last dma");
    chk(state_code == 2'b00 && r0_ptr == 16'd3, "R6 return to fetch, r0 = 3", {state_code, r0_ptr}, 3);
    quiet();

    // R9 idle with load mode
    mc("R3 fetch");
    instr_done = 0; is_idle = 1; load_mode = 1;
    mc("R9 idle load 1");
    mc("R9 idle load 2");
    chk(state_code == 2'b01, "R9 idle repeats", state_code, 1);
    dma_in_req = 1;
    mc("R9 idle leaves on dma");
    chk(state_code == 2'b10, "R9 dma from idle", state_code, 2);
    drain("R6 drain");

    // R5 R7 sweep over requests and enable
    for (int c = 0; c < 16; c++) begin
      int expst;
      quiet();
      mc("R3 fetch");
      des_wr = 1; des_x = 4'(c); des_p = 4'(15 - c); des_ie = c[3];
      ext_flags = 4'(c);
      mc("R10 sweep write");
      quiet();
      mc("R3 fetch");
      dma_in_req = c[0]; dma_out_req = c[1]; irq_req = c[2];
      expst = (c[0] | c[1]) ? 2 : ((c[2] & c[3]) ? 3 : 0);
      mc("R5 sweep decision");
      chk(state_code == 2'(expst), "R5 sweep next state", state_code, expst);
      drain("R5 sweep drain");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule